// File: doc/BRIEF.md
# Dual-Clock 8-bit Timer with Compare

This block is an 8-bit timer/counter with one output-compare channel, a waveform output pin and two interrupt requests. The timer clock has two possible sources. One is a prescaled copy of the system clock. The other is a separate, slower oscillator clock. That oscillator clock is brought into the system clock domain through a two-flop synchronizer and an edge detector, so the counter and all of its state stay in one clock domain. Software uses a small register port on the system clock to program the clock source, the waveform mode, the count direction, the counter value and the compare value. The same port gives access to the interrupt flags and their enables.

There are two waveform modes. In toggle mode the pin inverts on every compare match, and the counter reloads on that match. This gives a programmable output frequency. In fast PWM mode the counter always counts up through 0..0xFF. The pin is high from BOTTOM up to and including the compare value, and low after it. The compare register is double-buffered. In fast PWM mode a new duty value takes effect only at the TOP-to-BOTTOM wrap, so a PWM update never produces a glitch. In toggle mode a compare write takes effect at once.

Register map (3-bit address). Address 0 is control:
- bits [2:0] select the clock source: 0 stop, 1 ÷1, 2 ÷8, 3 ÷64, 4 ÷256, 5 ÷1024, 6 oscillator, 7 stop.
- bit 3 selects the mode: 0 toggle, 1 fast PWM.
- bit 4 sets down-counting, which applies in toggle mode only.

Address 1 is the counter. Address 2 is the compare buffer. Address 3 holds the flags: bit 0 is overflow and bit 1 is compare. Address 4 holds the interrupt enables, in the same bit positions as the flags. Unused addresses read as 0.

Top module: `dual_clk_timer`

## Requirements
- R1: After reset the control, counter, compare, flag and enable registers all read 0, both interrupt requests are low and `wavePin` is low.
- R2: With clock source 0 or 7 the counter holds its value. With source 6 and no rising edge on `asyncClk`, the counter also holds its value.
- R3: A write to the control register restarts the prescaler. With source 1..5, dividing by N = 1, 8, 64, 256 or 1024, the counter has advanced by floor(n/N) exactly n system clock edges after that write edge.
- R4: With source 6 the counter advances once for each rising edge of `asyncClk`. A pulse that is held high and low for at least two system clock cycles each is counted exactly once, three system clock edges after it rises.
- R5: The overflow flag (flag bit 0) sets when the counter steps from 0xFF to 0x00 while counting up. It also sets when the counter steps from 0x00 to 0xFF while counting down (control bit 4 = 1, toggle mode).
- R6: In toggle mode a timer tick with counter equal to the active compare value inverts `wavePin` and sets the compare flag (flag bit 1). The counter then reloads to 0x00 when counting up, or to 0xFF when counting down.
- R7: In fast PWM mode (control bit 3 = 1), `wavePin` goes high on the 0xFF-to-0x00 wrap and goes low on the tick where the counter equals the active compare value. A buffered compare value becomes active only at that wrap.
- R8: Reading the compare address returns the last value written. In toggle mode that value becomes the active compare value at the write edge.
- R9: Writing the flag register with a 1 in a bit position clears that flag. A 0 leaves it unchanged. A flag event in the same cycle wins over the clear.
- R10: `irqOvf` and `irqCmp` are each the AND of a flag and its enable bit. A one-cycle pulse on `ackOvf` or `ackCmp` clears the matching flag.
- R11: A counter write sets the counter to the written value at the write edge. It overrides any timer tick in that cycle, and that tick produces no flag event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| asyncClk | input | 1 | Slow oscillator clock, asynchronous to `clk` |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register read data, combinational from `addr` |
| ackOvf | input | 1 | Overflow interrupt acknowledge |
| ackCmp | input | 1 | Compare interrupt acknowledge |
| irqOvf | output | 1 | Overflow interrupt request |
| irqCmp | output | 1 | Compare interrupt request |
| wavePin | output | 1 | Waveform output |

## Verification
The assertions assume that `asyncClk` holds each level for at least two system clock cycles. Without that, the edge detector cannot see every oscillator edge, and the one-count-per-edge property would not hold. The bench drives `asyncClk` on falling edges of `clk` and holds each level for three cycles. The assertions also assume that register writes and acknowledge inputs are single-cycle strobes that are stable around the rising edge of `clk`. The bench drives every write, read address and acknowledge on the falling edge and releases it one cycle later.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CNT  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_CMP  = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_FLAG = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_MASK = 3'd4;

  typedef enum logic [0:0] {
    MODE_TOGGLE  = 1'b0,
    MODE_FASTPWM = 1'b1
  } waveMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic              tick;
    logic              cntWr;
    logic              cmpWr;
    logic              countDown;
    waveMode_e         mode;
    logic [DATA_W-1:0] wrData;
  } dpStrobe_t;

  // events from datapath back to control
  typedef struct packed {
    logic ovfEvt;
    logic cmpEvt;
  } dpEvent_t;

endpackage

// File: rtl/tmr_clksel.sv
module tmr_clksel #(
  parameter int PRE_W = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       restart,
  input  logic [2:0] sel,
  input  logic       asyncClk,
  output logic       tick
);
  localparam int NUM_DIV = 5;
  localparam int TAP [NUM_DIV] = '{0, 3, 6, 8, 10};

  logic [PRE_W-1:0]   preCnt;
  logic [NUM_DIV-1:0] divHit;
  logic               syncA, syncB, syncC;
  logic               asyncTick;

  // free-running prescaler, restarted by control writes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        preCnt <= '0;
    else if (restart) preCnt <= '0;
    else              preCnt <= preCnt + 1'b1;
  end

  for (genvar i = 0; i < NUM_DIV; i++) begin : g_tap
    if (TAP[i] == 0) begin : g_full
      assign divHit[i] = 1'b1;
    end else begin : g_div
      assign divHit[i] = &preCnt[TAP[i]-1:0];
    end
  end

  // oscillator clock brought into the system domain, rising-edge detect
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
      syncC <= 1'b0;
    end else begin
      syncA <= asyncClk;
      syncB <= syncA;
      syncC <= syncB;
    end
  end
  assign asyncTick = syncB & ~syncC;

  always_comb begin
    case (sel)
      3'd1, 3'd2, 3'd3, 3'd4, 3'd5: tick = divHit[sel - 3'd1];
      3'd6:                         tick = asyncTick;
      default:                      tick = 1'b0;
    endcase
  end

  // R4: an oscillator edge yields exactly one tick (no two ticks back to back)
  assert_async_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    (sel == 3'd6 && asyncTick) |=> !asyncTick);

endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int PRE_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              asyncClk,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              ackOvf,
  input  logic              ackCmp,
  input  logic [DATA_W-1:0] cntVal,
  input  logic [DATA_W-1:0] cmpBuf,
  input  dpEvent_t          evt,
  output dpStrobe_t         strb,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOvf,
  output logic              irqCmp
);
  logic [2:0] clkSel;
  waveMode_e  modeReg;
  logic       downReg;
  logic       flagOvf, flagCmp;
  logic       maskOvf, maskCmp;
  logic       wrCtrl, wrFlag, wrMask;
  logic       tick;

  assign wrCtrl = wrEn && (addr == ADDR_CTRL);
  assign wrFlag = wrEn && (addr == ADDR_FLAG);
  assign wrMask = wrEn && (addr == ADDR_MASK);

  tmr_clksel #(.PRE_W(PRE_W)) u_clksel (
    .clk      (clk),
    .rstN     (rstN),
    .restart  (wrCtrl),
    .sel      (clkSel),
    .asyncClk (asyncClk),
    .tick     (tick)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkSel  <= '0;
      modeReg <= MODE_TOGGLE;
      downReg <= 1'b0;
      maskOvf <= 1'b0;
      maskCmp <= 1'b0;
    end else begin
      if (wrCtrl) begin
        clkSel  <= wrData[2:0];
        modeReg <= waveMode_e'(wrData[3]);
        downReg <= wrData[4];
      end
      if (wrMask) begin
        maskOvf <= wrData[0];
        maskCmp <= wrData[1];
      end
    end
  end

  // flags: event wins over write-one-to-clear and acknowledge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagOvf <= 1'b0;
      flagCmp <= 1'b0;
    end else begin
      flagOvf <= evt.ovfEvt | (flagOvf & ~((wrFlag & wrData[0]) | ackOvf));
      flagCmp <= evt.cmpEvt | (flagCmp & ~((wrFlag & wrData[1]) | ackCmp));
    end
  end

  always_comb begin
    strb.tick      = tick;
    strb.cntWr     = wrEn && (addr == ADDR_CNT);
    strb.cmpWr     = wrEn && (addr == ADDR_CMP);
    strb.countDown = downReg;
    strb.mode      = modeReg;
    strb.wrData    = wrData;
  end

  always_comb begin
    rdData = '0;
    case (addr)
      ADDR_CTRL: rdData = {3'b000, downReg, modeReg, clkSel};
      ADDR_CNT:  rdData = cntVal;
      ADDR_CMP:  rdData = cmpBuf;
      ADDR_FLAG: rdData = {6'b0, flagCmp, flagOvf};
      ADDR_MASK: rdData = {6'b0, maskCmp, maskOvf};
      default:   rdData = '0;
    endcase
  end

  assign irqOvf = flagOvf & maskOvf;
  assign irqCmp = flagCmp & maskCmp;

  assert_ovf_sets_R5: assert property (@(posedge clk) disable iff (!rstN)
    evt.ovfEvt |=> flagOvf);
  assert_cmp_sets_R6: assert property (@(posedge clk) disable iff (!rstN)
    evt.cmpEvt |=> flagCmp);
  assert_w1c_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_FLAG && wrData[0] && !evt.ovfEvt) |=> !flagOvf);
  assert_ack_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ackCmp && !evt.cmpEvt) |=> !irqCmp);

endmodule

// File: rtl/tmr_dp.sv
module tmr_dp
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  output logic [DATA_W-1:0] cntVal,
  output logic [DATA_W-1:0] cmpBuf,
  output dpEvent_t          evt,
  output logic              wave
);
  localparam logic [DATA_W-1:0] TOP    = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] BOTTOM = '0;

  logic [DATA_W-1:0] cmpAct;
  logic              isPwm, goDown, tickEff, match, atEnd;

  assign isPwm   = (strb.mode == MODE_FASTPWM);
  assign goDown  = strb.countDown && !isPwm;
  assign tickEff = strb.tick && !strb.cntWr;
  assign match   = (cntVal == cmpAct);
  assign atEnd   = goDown ? (cntVal == BOTTOM) : (cntVal == TOP);

  assign evt.ovfEvt = tickEff && atEnd;
  assign evt.cmpEvt = tickEff && match;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntVal <= '0;
    end else if (strb.cntWr) begin
      cntVal <= strb.wrData;
    end else if (tickEff) begin
      if (!isPwm && match) cntVal <= goDown ? TOP : BOTTOM;
      else if (goDown)     cntVal <= cntVal - 1'b1;
      else                 cntVal <= cntVal + 1'b1;
    end
  end

  // double-buffered compare
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpBuf <= '0;
      cmpAct <= '0;
    end else begin
      if (strb.cmpWr) cmpBuf <= strb.wrData;
      if (strb.cmpWr && !isPwm)                   cmpAct <= strb.wrData;
      else if (isPwm && tickEff && cntVal == TOP) cmpAct <= cmpBuf;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wave <= 1'b0;
    end else if (tickEff) begin
      if (isPwm) begin
        if (cntVal == TOP) wave <= 1'b1;
        else if (match)    wave <= 1'b0;
      end else if (match) begin
        wave <= ~wave;
      end
    end
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.tick && !strb.cntWr) |=> $stable(cntVal));
  assert_toggle_R6: assert property (@(posedge clk) disable iff (!rstN)
    (tickEff && !isPwm && match) |=> (wave != $past(wave)));
  assert_pwm_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    (tickEff && isPwm && cntVal == TOP) |=> (wave && cntVal == BOTTOM));
  assert_cnt_write_R11: assert property (@(posedge clk) disable iff (!rstN)
    strb.cntWr |=> (cntVal == $past(strb.wrData)));

endmodule

// File: rtl/dual_clk_timer.sv
module dual_clk_timer
  import tmr_pkg::*;
#(
  parameter int PRE_W = 10
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        asyncClk,
  input  logic        wrEn,
  input  logic [2:0]  addr,
  input  logic [7:0]  wrData,
  output logic [7:0]  rdData,
  input  logic        ackOvf,
  input  logic        ackCmp,
  output logic        irqOvf,
  output logic        irqCmp,
  output logic        wavePin
);
  dpStrobe_t         strb;
  dpEvent_t          evt;
  logic [DATA_W-1:0] cntVal, cmpBuf;

  tmr_ctrl #(.PRE_W(PRE_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .asyncClk (asyncClk),
    .wrEn     (wrEn),
    .addr     (addr),
    .wrData   (wrData),
    .ackOvf   (ackOvf),
    .ackCmp   (ackCmp),
    .cntVal   (cntVal),
    .cmpBuf   (cmpBuf),
    .evt      (evt),
    .strb     (strb),
    .rdData   (rdData),
    .irqOvf   (irqOvf),
    .irqCmp   (irqCmp)
  );

  tmr_dp u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .cntVal (cntVal),
    .cmpBuf (cmpBuf),
    .evt    (evt),
    .wave   (wavePin)
  );

endmodule

// File: tb/tb_dual_clk_timer.sv
module tb_dual_clk_timer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       asyncClk = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       ackOvf = 1'b0, ackCmp = 1'b0;
  logic       irqOvf, irqCmp, wavePin;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  localparam logic [2:0] A_CTRL = 3'd0, A_CNT = 3'd1, A_CMP = 3'd2,
                         A_FLAG = 3'd3, A_MASK = 3'd4;

  // {clock source, edges after control write, expected count}  (R2, R3)
  localparam int NVEC = 14;
  localparam logic [23:0] VEC [NVEC] = '{
    {4'd1, 12'd5,    8'd5},
    {4'd1, 12'd0,    8'd0},
    {4'd2, 12'd7,    8'd0},
    {4'd2, 12'd8,    8'd1},
    {4'd2, 12'd23,   8'd2},
    {4'd3, 12'd63,   8'd0},
    {4'd3, 12'd64,   8'd1},
    {4'd4, 12'd600,  8'd2},
    {4'd5, 12'd1023, 8'd0},
    {4'd5, 12'd1024, 8'd1},
    {4'd0, 12'd40,   8'd0},
    {4'd7, 12'd40,   8'd0},
    {4'd6, 12'd40,   8'd0},
    {4'd3, 12'd200,  8'd3}
  };

  dual_clk_timer dut (
    .clk(clk), .rstN(rstN), .asyncClk(asyncClk), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .ackOvf(ackOvf), .ackCmp(ackCmp),
    .irqOvf(irqOvf), .irqCmp(irqCmp), .wavePin(wavePin)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdData;
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (60000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] d;
    logic       w0;
    edges(3);
    rstN = 1'b1;
    edges(1);

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d);
      check("R1 register", d, 8'h00);
    end
    check("R1 irqOvf", {7'b0, irqOvf}, 8'h0);
    check("R1 irqCmp", {7'b0, irqCmp}, 8'h0);
    check("R1 wavePin", {7'b0, wavePin}, 8'h0);

    // vector table: clock sources and prescaler ratios (R2, R3)
    wr(A_CMP, 8'hFF);
    for (int i = 0; i < NVEC; i++) begin
      wr(A_CTRL, 8'h00);
      wr(A_CNT, 8'h00);
      wr(A_CTRL, {4'b0, VEC[i][23:20]});
      edges(int'(VEC[i][19:8]));
      rd(A_CNT, d);
      check((VEC[i][23:20] inside {4'd0, 4'd6, 4'd7}) ? "R2 stopped" : "R3 divide",
            d, VEC[i][7:0]);
    end

    // R4 oscillator clock: five pulses, three cycles per level
    wr(A_CTRL, 8'h00);
    wr(A_CNT, 8'h00);
    wr(A_CTRL, 8'h06);
    for (int p = 0; p < 5; p++) begin
      asyncClk = 1'b1; edges(3);
      asyncClk = 1'b0; edges(3);
    end
    edges(4);
    rd(A_CNT, d);
    check("R4 oscillator count", d, 8'd5);

    // R5 overflow counting up
    wr(A_CTRL, 8'h00);
    wr(A_CMP, 8'h80);
    wr(A_CNT, 8'hFD);
    wr(A_FLAG, 8'h03);
    wr(A_CTRL, 8'h01);
    edges(2);
    rd(A_FLAG, d); check("R5 no flag before wrap", d, 8'h00);
    edges(1);
    rd(A_FLAG, d); check("R5 overflow up flag", d, 8'h01);
    rd(A_CNT, d);  check("R5 wrapped count", d, 8'h00);
    wr(A_CTRL, 8'h00);

    // R9 write-zero and other-bit writes leave the overflow flag
    wr(A_FLAG, 8'h00);
    rd(A_FLAG, d); check("R9 write zero keeps", d, 8'h01);
    wr(A_FLAG, 8'h02);
    rd(A_FLAG, d); check("R9 other bit keeps", d, 8'h01);

    // R10 masking and acknowledge
    check("R10 masked irq", {7'b0, irqOvf}, 8'h0);
    wr(A_MASK, 8'h01);
    check("R10 enabled irq", {7'b0, irqOvf}, 8'h1);
    @(negedge clk); ackOvf = 1'b1;
    @(negedge clk); ackOvf = 1'b0;
    check("R10 ack clears irq", {7'b0, irqOvf}, 8'h0);
    rd(A_FLAG, d); check("R10 ack clears flag", d, 8'h00);

    // R5 overflow counting down, then R9 clear
    wr(A_CNT, 8'h02);
    wr(A_CTRL, 8'h11);
    edges(3);
    rd(A_CNT, d);  check("R5 down wrap count", d, 8'hFF);
    rd(A_FLAG, d); check("R5 overflow down flag", d, 8'h01);
    wr(A_CTRL, 8'h00);
    wr(A_FLAG, 8'h01);
    rd(A_FLAG, d); check("R9 write one clears", d, 8'h00);

    // R6 / R8 toggle mode, compare effective at write
    wr(A_CMP, 8'h05);
    wr(A_CNT, 8'h00);
    w0 = wavePin;
    wr(A_CTRL, 8'h01);
    edges(5);
    rd(A_CNT, d); check("R8 count before match", d, 8'h05);
    check("R6 wave before match", {7'b0, wavePin}, {7'b0, w0});
    edges(1);
    rd(A_CNT, d);  check("R6 reload on match", d, 8'h00);
    rd(A_FLAG, d); check("R6 compare flag", d, 8'h02);
    check("R6 wave toggled", {7'b0, wavePin}, {7'b0, ~w0});
    edges(6);
    check("R6 wave toggled back", {7'b0, wavePin}, {7'b0, w0});

    // R11 counter write overrides running tick
    wr(A_CNT, 8'h40);
    rd(A_CNT, d); check("R11 written value", d, 8'h40);
    edges(1);
    rd(A_CNT, d); check("R11 counts on", d, 8'h41);
    wr(A_CTRL, 8'h00);

    // R7 / R8 fast PWM with buffered compare
    wr(A_CMP, 8'h03);
    wr(A_CTRL, 8'h08);
    wr(A_CNT, 8'hFE);
    wr(A_CMP, 8'h0A);
    rd(A_CMP, d); check("R8 readback buffer", d, 8'h0A);
    wr(A_CTRL, 8'h09);
    edges(2);
    rd(A_CNT, d); check("R7 wrap to bottom", d, 8'h00);
    check("R7 set at bottom", {7'b0, wavePin}, 8'h1);
    edges(4);
    check("R7 old compare not used", {7'b0, wavePin}, 8'h1);
    edges(6);
    check("R7 high through compare", {7'b0, wavePin}, 8'h1);
    edges(1);
    check("R7 cleared after compare", {7'b0, wavePin}, 8'h0);
    wr(A_CTRL, 8'h00);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule